// File: doc/BRIEF.md
# Multiplexed ADC Conversion Controller

This block sits between a host register bus and a ten-input multiplexed analog-to-digital converter. The host writes one 16-bit control word. That word selects which inputs are allowed to convert, which input to convert and read, and whether to wait an extra settling time before the sample is taken. Setting its start bit launches a single conversion.

The controller drives the mux select and waits the settling time when it is asked to. It then requests a sample over a request/acknowledge interface and stores the result, converted to two's complement, in a read-only data register. Inputs 0 to 7 are differential pairs. Input 8 is the +10 V reference and input 9 is the 0 V reference.

When a conversion ends, a done flag is set in the interrupt status register. Software either polls that flag with a timeout or enables it as an interrupt. Software then clears the flag by writing 1 to it. Registers sit at word addresses 0 (control), 1 (data), 2 (interrupt status) and 3 (interrupt enable).

Top module: `adc_conv_ctrl`

## Requirements
- R1: Control word layout: bit 0 is start, bits 4:1 are the channel index, bits 14:5 are the enable mask (bit 5+n enables channel n), and bit 15 requests the settling delay. Address 0 reads back bits 15:1 as written, and bit 0 always reads 0.
- R2: A control write with bit 0 set while idle launches one conversion. During that conversion `adc_chan` carries the index from bits 4:1 and `adc_req` is raised for that channel.
- R3: While a conversion is in progress, a write to address 0 is ignored. The stored fields stay unchanged and no second conversion starts.
- R4: With bit 15 set, the ADC request is raised exactly SETTLE_CYCLES clock cycles later than it is with bit 15 clear.
- R5: The data register (address 1) holds the sample with its MSB inverted, so offset-binary ADC codes appear as two's complement. It changes only when a conversion completes.
- R6: A conversion on a channel whose enable bit is clear, or whose index is 10 or higher, raises no ADC request, still completes, and stores 0x0000.
- R7: Completion sets bit 2 of the interrupt status register (address 2). Writing a word with bit 2 set clears it. Writing a word with bit 2 clear leaves it set.
- R8: `irq` is high exactly when status bit 2 and interrupt-enable bit 2 (address 3) are both 1. Other enable bits have no effect.
- R9: After reset, all four registers read 0x0000, and `irq` and `adc_req` are low.
- R10: Once raised, `adc_req` stays high until `adc_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Conversion-done interrupt |
| adc_req | output | 1 | Sample request to the converter |
| adc_chan | output | 4 | Mux channel select |
| adc_ack | input | 1 | Sample valid from the converter |
| adc_sample | input | 16 | Offset-binary sample |

## Verification
The in-line assertions check, on every cycle, the properties that hold at all times:
- the control fields are frozen while a conversion runs;
- the request is held until it is acknowledged;
- the settling counter stays in range;
- the done flag rises only on a completion and falls after a write-1 clear;
- the data register changes only on a completion.

Other behaviours depend on the host's choice of control word, so only the bench's scenarios can show them:
- the exact settling delay in cycles;
- the MSB inversion of the stored sample;
- the zero result and missing request for disabled or out-of-range channels;
- the interrupt gating.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_SAMPLE = 2'd2
  } seq_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_IEN  = 2'd3;
endpackage

// File: rtl/adc_seq.sv
module adc_seq
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_dly,
  input  logic              ch_ok,
  input  logic              adc_ack,
  input  logic [DATA_W-1:0] adc_sample,
  output logic              busy,
  output logic              adc_req,
  output logic              done_pulse,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    done_pulse = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          cnt_d   = '0;
          state_d = start_dly ? ST_SETTLE : ST_SAMPLE;
        end
      end
      ST_SETTLE: begin
        if (cnt_q == CNT_LAST) state_d = ST_SAMPLE;
        else                   cnt_d   = cnt_q + 1'b1;
      end
      ST_SAMPLE: begin
        if (!ch_ok || adc_ack) begin
          done_pulse = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign adc_req = (state_q == ST_SAMPLE) && ch_ok;
  assign result  = ch_ok ? {~adc_sample[DATA_W-1], adc_sample[DATA_W-2:0]} : '0;

  // R4: settle counter never exceeds the programmed window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |-> (cnt_q < CNT_W'(SETTLE_CYCLES)));

  // R10: request held until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack) |=> adc_req);
endmodule

// File: rtl/adc_regs.sv
module adc_regs
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int IDX_W    = 4,
  parameter int NUM_CH   = 10,
  parameter int DONE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              done_pulse,
  input  logic [DATA_W-1:0] result,
  output logic [IDX_W-1:0]  ctrl_idx,
  output logic [NUM_CH-1:0] ctrl_en,
  output logic              start,
  output logic              start_dly,
  output logic              irq
);
  localparam int EN_LSB  = IDX_W + 1;
  localparam int DLY_BIT = EN_LSB + NUM_CH;

  logic [DATA_W-1:1] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              done_q, done_d;
  logic              ien_q, ien_d;
  logic              wr_ctrl, wr_stat, wr_ien;

  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL) && !busy;
  assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);
  assign wr_ien  = reg_wr && (reg_addr == ADDR_IEN);

  assign start     = wr_ctrl && reg_wdata[0];
  assign start_dly = reg_wdata[DLY_BIT];

  always_comb begin
    ctrl_d = ctrl_q;
    data_d = data_q;
    done_d = done_q;
    ien_d  = ien_q;
    if (wr_ctrl)                        ctrl_d = reg_wdata[DATA_W-1:1];
    if (done_pulse)                     data_d = result;
    if (wr_stat && reg_wdata[DONE_BIT]) done_d = 1'b0;
    if (done_pulse)                     done_d = 1'b1;
    if (wr_ien)                         ien_d  = reg_wdata[DONE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      data_q <= data_d;
      done_q <= done_d;
      ien_q  <= ien_d;
    end
  end

  assign ctrl_idx = ctrl_q[IDX_W:1];
  assign ctrl_en  = ctrl_q[DLY_BIT-1:EN_LSB];
  assign irq      = done_q && ien_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {ctrl_q, 1'b0};
      ADDR_DATA: reg_rdata = data_q;
      ADDR_STAT: reg_rdata[DONE_BIT] = done_q;
      default:   reg_rdata[DONE_BIT] = ien_q;
    endcase
  end

  // R3: control fields frozen while a conversion is running
  p_ctrl_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ctrl_q));

  // R7: done flag rises only after a completion
  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(done_pulse));

  // R7: a write-1 clear without a concurrent completion drops the flag
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_STAT && reg_wdata[DONE_BIT] && !done_pulse) |=> !done_q);

  // R5: data register moves only on completion
  p_data_update_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_q) |-> $past(done_pulse));
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int IDX_W         = 4,
  parameter int NUM_CH        = 10,
  parameter int DONE_BIT      = 2,
  parameter int SETTLE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              adc_req,
  output logic [IDX_W-1:0]  adc_chan,
  input  logic              adc_ack,
  input  logic [DATA_W-1:0] adc_sample
);
  localparam int IDX_SPAN = 1 << IDX_W;

  logic              rst_meta, rst_sync;
  logic              busy, done_pulse, start, start_dly, ch_ok;
  logic [DATA_W-1:0] result;
  logic [NUM_CH-1:0] ctrl_en;
  logic [IDX_SPAN-1:0] en_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  for (genvar i = 0; i < IDX_SPAN; i++) begin : g_en
    if (i < NUM_CH) begin : g_real
      assign en_pad[i] = ctrl_en[i];
    end else begin : g_none
      assign en_pad[i] = 1'b0;
    end
  end

  assign ch_ok = en_pad[adc_chan];

  adc_regs #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH), .DONE_BIT(DONE_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .done_pulse(done_pulse), .result(result),
    .ctrl_idx(adc_chan), .ctrl_en(ctrl_en),
    .start(start), .start_dly(start_dly), .irq(irq)
  );

  adc_seq #(
    .DATA_W(DATA_W), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_sync),
    .start(start), .start_dly(start_dly), .ch_ok(ch_ok),
    .adc_ack(adc_ack), .adc_sample(adc_sample),
    .busy(busy), .adc_req(adc_req), .done_pulse(done_pulse), .result(result)
  );

  // R2: a conversion never starts while one is already running
  p_single_conv_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    busy |-> !start);
endmodule

// File: tb/sim_adc_conv_ctrl.sv
module sim_adc_stub #(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [3:0]  chan,
  output logic        ack,
  output logic [15:0] sample
);
  logic [7:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ack <= 1'b0; sample <= '0;
    end else if (ack) begin
      ack <= 1'b0; cnt <= '0;
    end else if (req) begin
      if (cnt == 8'(LAT - 1)) begin
        ack    <= 1'b1;
        sample <= 16'({12'h0, chan} * 16'h1111 + 16'h0F0F);
        cnt    <= '0;
      end else cnt <= cnt + 1'b1;
    end else cnt <= '0;
  end
endmodule

module sim_adc_conv_ctrl;
  localparam int SETTLE = 64;

  logic        clk, rst_n, reg_wr, irq, adc_req, adc_ack;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, adc_sample;
  logic [3:0]  adc_chan;

  int n_tests = 0;
  int n_fail  = 0;
  bit ended   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  adc_conv_ctrl #(.SETTLE_CYCLES(SETTLE)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(adc_ack), .adc_sample(adc_sample)
  );

  sim_adc_stub #(.LAT(4)) u_stub (
    .clk(clk), .rst_n(rst_n), .req(adc_req), .chan(adc_chan),
    .ack(adc_ack), .sample(adc_sample)
  );

  // {control word, expected data, expect request}
  localparam logic [32:0] VEC [6] = '{
    {16'h0021, 16'h8F0F, 1'b1},
    {16'h7FE7, 16'hC242, 1'b1},
    {16'hA011, 16'h1797, 1'b1},
    {16'h4013, 16'h28A8, 1'b1},
    {16'h7BEB, 16'h0000, 1'b0},
    {16'h7FF9, 16'h0000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // start conversion, watch request, wait for done flag (no clear)
  task automatic run_conv(input logic [15:0] w, output bit saw, output logic [3:0] ch,
                          output int req_at);
    saw = 0; ch = '0; req_at = -1;
    wr_reg(2'd0, w);
    reg_addr = 2'd2;
    for (int k = 1; k < 400; k++) begin
      #1;
      if (adc_req && !saw) begin saw = 1; ch = adc_chan; req_at = k; end
      if (reg_rdata[2]) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [3:0]  ch;
    bit          saw;
    int          t0, t1;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R9: reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(2'(a), d);
      chk(d == 16'h0, "R9 reg after reset", d, 0);
    end
    chk(!irq && !adc_req, "R9 irq/req after reset", {irq, adc_req}, 0);

    // table walk: R1 R2 R5 R6 R7
    for (int v = 0; v < 6; v++) begin
      logic [15:0] w, e;
      bit er;
      int ra;
      {w, e, er} = VEC[v];
      run_conv(w, saw, ch, ra);
      rd_reg(2'd2, d);
      chk(d[2], "R7 done set", d, 16'h4);
      rd_reg(2'd1, d);
      chk(d == e, "R5/R6 data", d, e);
      rd_reg(2'd0, d);
      chk(d == (w & 16'hFFFE), "R1 ctrl readback", d, w & 16'hFFFE);
      chk(saw == er, "R6 request presence", saw, er);
      if (er) chk(ch == w[4:1], "R2 channel select", ch, w[4:1]);
      wr_reg(2'd2, 16'hFFFB);
      rd_reg(2'd2, d);
      chk(d[2], "R7 write-0 keeps flag", d, 16'h4);
      wr_reg(2'd2, 16'h0004);
      rd_reg(2'd2, d);
      chk(d == 16'h0, "R7 W1C clears", d, 0);
    end

    // R4: settling delay
    run_conv(16'h0021, saw, ch, t0);
    wr_reg(2'd2, 16'h0004);
    run_conv(16'h8021, saw, ch, t1);
    wr_reg(2'd2, 16'h0004);
    chk(t1 - t0 == SETTLE, "R4 delay cycles", t1 - t0, SETTLE);

    // R3: write while busy is ignored
    wr_reg(2'd0, 16'hA011);
    wr_reg(2'd0, 16'h0021);
    rd_reg(2'd0, d);
    chk(d == 16'hA010, "R3 ctrl unchanged while busy", d, 16'hA010);
    reg_addr = 2'd2;
    for (int k = 0; k < 400; k++) begin
      #1; if (reg_rdata[2]) break;
      @(negedge clk);
    end
    rd_reg(2'd1, d);
    chk(d == 16'h1797, "R3 first conversion result kept", d, 16'h1797);
    wr_reg(2'd2, 16'h0004);
    saw = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); if (adc_req) saw = 1;
    end
    chk(!saw, "R3 no second conversion", saw, 0);

    // R8: interrupt gating
    wr_reg(2'd3, 16'h0004);
    run_conv(16'h0021, saw, ch, t0);
    @(negedge clk);
    chk(irq, "R8 irq when enabled", irq, 1);
    wr_reg(2'd2, 16'h0004);
    @(negedge clk);
    chk(!irq, "R8 irq after clear", irq, 0);
    wr_reg(2'd3, 16'hFFFB);
    run_conv(16'h0021, saw, ch, t0);
    @(negedge clk);
    chk(!irq, "R8 irq masked", irq, 0);
    rd_reg(2'd3, d);
    chk(d == 16'h0, "R8 enable readback", d, 0);
    wr_reg(2'd2, 16'h0004);

    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule